// File: doc/BRIEF.md
# Grouped Pin-Change and External Interrupt Controller

This block watches sixteen general-purpose input pins, split into a lower and an upper group of eight, plus one dedicated external interrupt pin, and turns activity on them into three interrupt request lines for a processor core. Each general-purpose pin has its own bit in its group's 8-bit mask. A logic change on any unmasked pin of a group latches that group's single pending flag. The dedicated pin has a 2-bit sense control: it can be level-sensitive (active low) or it can latch its flag on any edge, only falling edges or only rising edges.

Software reaches the block through a byte-wide register port. An enable register gates each source. A flag register shows pending events and clears a flag when a one is written to it. Two mask registers and a sense register complete the set. A request reaches the core only when the source is pending, the source is enabled and the core's global interrupt enable is high. When the core takes an interrupt it pulses the acknowledge line for that source, and this clears the flag. All pins pass through a two-flop synchronizer before detection.

Top module: `edge_irq_hub`

## Requirements
- R1: After reset, every register reads 0x00 and no request is raised. Register addresses: 0 = enable, 1 = flags, 2 = lower mask (pin i at bit i), 3 = upper mask (pin 8+i at bit i), 4 = sense (bits 1:0).
- R2: In the enable register, bit 7 enables the upper group, bit 6 enables the lower group and bit 0 enables the dedicated pin. Bits 5 to 1 ignore writes and read as zero.
- R3: The flag register uses the same positions: bit 7 for the upper group, bit 6 for the lower group and bit 0 for the dedicated pin. Bits 5 to 1 read as zero.
- R4: A change on a pin whose mask bit is one sets that group's flag. The flag is readable on the third rising clock edge after the pin changes. A change on a masked pin sets nothing.
- R5: irq_req[2] (upper group), irq_req[1] (lower group) and irq_req[0] (dedicated pin) are each high exactly when the source is pending, its enable bit is one and gie is high.
- R6: Writing a one to a flag bit clears that flag. Writing a zero to it leaves the flag unchanged.
- R7: A one-cycle pulse on irq_ack[i] clears the flag of source i, using the bit order of R5.
- R8: When a new event and a clear (by write or by acknowledge) reach the same flag in the same cycle, the flag stays set.
- R9: Sense code 01 latches the dedicated flag on any edge. Code 10 latches it only on falling edges. Code 11 latches it only on rising edges.
- R10: Sense code 00 latches no flag (flag bit 0 reads zero). irq_req[0] is then high while the synchronized pin is low and the pin is enabled, and it rises two clock edges after the pin falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_pins | input | 16 | General-purpose pins; bits 7:0 lower group, bits 15:8 upper group |
| ext_pin | input | 1 | Dedicated external interrupt pin |
| gie | input | 1 | Global interrupt enable from the core |
| irq_ack | input | 3 | Acknowledge pulse per source |
| irq_req | output | 3 | Request line per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (shared by reads and writes) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational on reg_addr |

## Verification
A pin driven on a falling clock edge reaches the second synchronizer stage after two rising edges. The latched flag follows on the third, so edge-mode checks sample exactly three falling edges later. They also confirm that the flag is still clear one edge earlier. Level-mode requests do not pass through a flag, so they are sampled two edges after the pin moves. A register write or acknowledge driven on a falling edge takes effect at the next rising edge, and reads are combinational and sampled on the following falling edge. The set-beats-clear case places the clearing write in the one cycle in which the synchronized change is present, which is two falling edges after the pin toggles.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam int DATA_W     = 8;
    localparam int GROUP_W    = DATA_W;
    localparam int NUM_GROUPS = 2;
    localparam int NUM_SRC    = NUM_GROUPS + 1;
    localparam int ADDR_W     = 3;

    // source index: 0 = dedicated pin, 1 + g = group g
    localparam int SRC_EXT = 0;

    // register bit positions of each source
    localparam int BIT_EXT  = 0;
    localparam int BIT_GRP0 = 6;
    localparam int BIT_GRP1 = 7;

    localparam logic [ADDR_W-1:0] A_ENABLE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_FLAG    = 3'd1;
    localparam logic [ADDR_W-1:0] A_MASK_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_MASK_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_SENSE   = 3'd4;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef struct packed {
        logic [NUM_SRC-1:0]                   en;
        logic [NUM_SRC-1:0]                   flag;
        logic [NUM_GROUPS-1:0][GROUP_W-1:0]   mask;
        sense_e                               sense;
    } hub_regs_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = din;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.s2;
    assign rise  = st_q.s2 & ~st_q.prev;
    assign fall  = ~st_q.s2 & st_q.prev;
endmodule

// File: rtl/group_detect.sv
module group_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] mask,
    output logic         hit
);
    logic [W-1:0] lvl_unused;
    logic [W-1:0] up, dn;

    pin_sync #(.W(W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins),
        .level (lvl_unused),
        .rise  (up),
        .fall  (dn)
    );

    assign hit = |((up | dn) & mask);
endmodule

// File: rtl/ext_sense.sv
module ext_sense
    import irq_hub_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin,
    input  sense_e sense,
    output logic   edge_hit,
    output logic   low_now
);
    logic lvl, up, dn;

    pin_sync #(.W(1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin),
        .level (lvl),
        .rise  (up),
        .fall  (dn)
    );

    always_comb begin
        case (sense)
            SENSE_ANY:  edge_hit = up | dn;
            SENSE_FALL: edge_hit = dn;
            SENSE_RISE: edge_hit = up;
            default:    edge_hit = 1'b0;
        endcase
    end

    assign low_now = ~lvl;

    // R9: a rising-only selection never reports a falling transition
    assert_rise_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sense == SENSE_RISE && edge_hit) |-> lvl);
endmodule

// File: rtl/edge_irq_hub.sv
module edge_irq_hub
    import irq_hub_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_GROUPS*GROUP_W-1:0] grp_pins,
    input  logic                          ext_pin,
    input  logic                          gie,
    input  logic [NUM_SRC-1:0]            irq_ack,
    output logic [NUM_SRC-1:0]            irq_req,
    input  logic                          reg_wr,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata
);
    hub_regs_t r_d, r_q;

    logic [NUM_GROUPS-1:0] grp_hit;
    logic                  ext_edge, ext_low;
    logic [NUM_SRC-1:0]    set_v, clr_v, pend;

    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : gen_grp
            group_detect #(.W(GROUP_W)) u_grp (
                .clk   (clk),
                .rst_n (rst_n),
                .pins  (grp_pins[g*GROUP_W +: GROUP_W]),
                .mask  (r_q.mask[g]),
                .hit   (grp_hit[g])
            );
        end
    endgenerate

    ext_sense u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_pin),
        .sense    (r_q.sense),
        .edge_hit (ext_edge),
        .low_now  (ext_low)
    );

    function automatic logic [NUM_SRC-1:0] pick(input logic [DATA_W-1:0] b);
        return {b[BIT_GRP1], b[BIT_GRP0], b[BIT_EXT]};
    endfunction

    function automatic logic [DATA_W-1:0] place(input logic [NUM_SRC-1:0] s);
        logic [DATA_W-1:0] b;
        b           = '0;
        b[BIT_GRP1] = s[2];
        b[BIT_GRP0] = s[1];
        b[BIT_EXT]  = s[0];
        return b;
    endfunction

    always_comb begin
        r_d   = r_q;
        set_v = {grp_hit, ext_edge};
        clr_v = irq_ack;
        if (reg_wr) begin
            case (reg_addr)
                A_ENABLE:  r_d.en      = pick(reg_wdata);
                A_FLAG:    clr_v       = clr_v | pick(reg_wdata);
                A_MASK_LO: r_d.mask[0] = reg_wdata;
                A_MASK_HI: r_d.mask[1] = reg_wdata;
                A_SENSE:   r_d.sense   = sense_e'(reg_wdata[1:0]);
                default:   ;
            endcase
        end
        // a new event wins over a clear in the same cycle
        r_d.flag = (r_q.flag & ~clr_v) | set_v;
        if (r_q.sense == SENSE_LOW) r_d.flag[SRC_EXT] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        pend = r_q.flag;
        if (r_q.sense == SENSE_LOW) pend[SRC_EXT] = ext_low;
    end

    assign irq_req = pend & r_q.en & {NUM_SRC{gie}};

    always_comb begin
        case (reg_addr)
            A_ENABLE:  reg_rdata = place(r_q.en);
            A_FLAG:    reg_rdata = place(r_q.flag);
            A_MASK_LO: reg_rdata = r_q.mask[0];
            A_MASK_HI: reg_rdata = r_q.mask[1];
            A_SENSE:   reg_rdata = {{(DATA_W-2){1'b0}}, r_q.sense};
            default:   reg_rdata = '0;
        endcase
    end

    assert_req_needs_gie_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req) |-> gie);

    assert_level_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.sense == SENSE_LOW && $past(r_q.sense == SENSE_LOW)) |-> !r_q.flag[SRC_EXT]);

    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : gen_chk
            assert_group_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
                grp_hit[g] |=> r_q.flag[g+1]);

            assert_zero_write_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (r_q.flag[g+1] && !irq_ack[g+1] &&
                 !(reg_wr && reg_addr == A_FLAG && pick(reg_wdata)[g+1]))
                |=> r_q.flag[g+1]);

            assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_ack[g+1] && !grp_hit[g]) |=> !r_q.flag[g+1]);
        end
    endgenerate
endmodule

// File: tb/edge_irq_hub_test.sv
module edge_irq_hub_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] grp_pins = '0;
    logic        ext_pin = 1'b1;
    logic        gie = 1'b0;
    logic [2:0]  irq_ack = '0;
    logic [2:0]  irq_req;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_irq_hub uut (
        .clk(clk), .rst_n(rst_n), .grp_pins(grp_pins), .ext_pin(ext_pin),
        .gie(gie), .irq_ack(irq_ack), .irq_req(irq_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ack(input logic [2:0] v);
        irq_ack = v;
        step(1);
        irq_ack = '0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R1 reset register", v, 8'h00);
        end
        chk("R1 no request", {5'b0, irq_req}, 8'h00);
    endtask

    task automatic t_enable_bits;
        logic [7:0] v;
        wr(3'd0, 8'hFF);
        rd(3'd0, v);
        chk("R2 enable reserved bits", v, 8'hC1);
        wr(3'd0, 8'h3E);
        rd(3'd0, v);
        chk("R2 enable reserved write ignored", v, 8'h00);
    endtask

    task automatic t_lower_group;
        logic [7:0] v;
        wr(3'd2, 8'h04);
        wr(3'd0, 8'h40);
        gie = 1'b1;
        grp_pins[3] = 1'b1;               // masked pin
        step(3);
        rd(3'd1, v);
        chk("R4 masked pin ignored", v, 8'h00);
        grp_pins[2] = 1'b1;
        step(2);
        rd(3'd1, v);
        chk("R4 flag not before third edge", v, 8'h00);
        step(1);
        rd(3'd1, v);
        chk("R3 R4 lower flag at bit 6", v, 8'h40);
        chk("R5 lower request", {5'b0, irq_req}, 8'h02);
        wr(3'd1, 8'h40);
        rd(3'd1, v);
        chk("R6 write one clears", v, 8'h00);
    endtask

    task automatic t_upper_group;
        logic [7:0] v;
        wr(3'd3, 8'h80);
        grp_pins[15] = 1'b1;
        step(3);
        rd(3'd1, v);
        chk("R3 R4 upper flag at bit 7", v, 8'h80);
        chk("R5 upper not enabled", {5'b0, irq_req}, 8'h00);
        wr(3'd0, 8'hC0);
        chk("R5 upper enabled", {5'b0, irq_req}, 8'h04);
        gie = 1'b0;
        #1 chk("R5 gie low blocks", {5'b0, irq_req}, 8'h00);
        gie = 1'b1;
        wr(3'd1, 8'h3F);
        rd(3'd1, v);
        chk("R6 zero write keeps flag", v, 8'h80);
        ack(3'b100);
        rd(3'd1, v);
        chk("R7 ack clears upper", v, 8'h00);
    endtask

    task automatic t_set_beats_clear;
        logic [7:0] v;
        grp_pins[2] = 1'b0;
        step(3);                          // flag set again
        grp_pins[2] = 1'b1;
        step(2);                          // change present in this cycle
        wr(3'd1, 8'h40);
        rd(3'd1, v);
        chk("R8 set beats write clear", v, 8'h40);
        wr(3'd1, 8'h40);
        grp_pins[2] = 1'b0;
        step(2);
        ack(3'b010);
        rd(3'd1, v);
        chk("R8 set beats ack clear", v, 8'h40);
        ack(3'b010);
        rd(3'd1, v);
        chk("R7 ack clears lower", v, 8'h00);
    endtask

    task automatic t_ext_edges;
        logic [7:0] v;
        wr(3'd0, 8'h01);
        wr(3'd4, 8'h01);                  // any edge
        ext_pin = 1'b0;
        step(3);
        rd(3'd1, v);
        chk("R9 any edge falling", v, 8'h01);
        chk("R5 ext request", {5'b0, irq_req}, 8'h01);
        wr(3'd1, 8'h01);
        ext_pin = 1'b1;
        step(3);
        rd(3'd1, v);
        chk("R9 any edge rising", v, 8'h01);
        wr(3'd1, 8'h01);
        wr(3'd4, 8'h03);                  // rising only
        ext_pin = 1'b0;
        step(3);
        rd(3'd1, v);
        chk("R9 rising mode ignores fall", v, 8'h00);
        ext_pin = 1'b1;
        step(3);
        rd(3'd1, v);
        chk("R9 rising mode latches rise", v, 8'h01);
        wr(3'd1, 8'h01);
        wr(3'd4, 8'h02);                  // falling only
        ext_pin = 1'b0;
        step(3);
        rd(3'd1, v);
        chk("R9 falling mode latches fall", v, 8'h01);
        wr(3'd1, 8'h01);
        ext_pin = 1'b1;
        step(3);
        rd(3'd1, v);
        chk("R9 falling mode ignores rise", v, 8'h00);
    endtask

    task automatic t_ext_level;
        logic [7:0] v;
        wr(3'd4, 8'h00);
        step(1);
        ext_pin = 1'b0;
        step(1);
        chk("R10 not yet low", {5'b0, irq_req}, 8'h00);
        step(1);
        chk("R10 level request", {5'b0, irq_req}, 8'h01);
        step(2);
        rd(3'd1, v);
        chk("R10 no flag latched", v, 8'h00);
        ext_pin = 1'b1;
        step(2);
        chk("R10 request drops", {5'b0, irq_req}, 8'h00);
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        step(3);
        t_reset();
        t_enable_bits();
        t_lower_group();
        t_upper_group();
        t_set_beats_clear();
        t_ext_edges();
        t_ext_level();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule